// File: doc/BRIEF.md
# Dual-Channel Receive Peak Meter

This block watches the amplitude estimates of the in-phase and quadrature receive chains and keeps, for each chain, the largest value seen during one reception. Measurement runs in a window that opens when the receive wait timer expires and closes at the end of reception. After the window closes, both held peaks stay readable in one packed byte until the next transmission begins.

While the window is open, the block also decides which chain carries the stronger signal. It makes that choice at the end of the preamble and reports it as a single select bit. A valid flag shows when a completed measurement is available. The per-sample amplitudes come from upstream; this block only gates, compares and holds them.

Top module: `rssi_peak_capture`

## Requirements
- R1: After reset, `peak_reg` is 0, `chan_sel` is 0 and `peaks_valid` is 0.
- R2: A `rx_wait_done` pulse (without `tx_start`) opens the window. At the next clock edge it clears both peaks and `peaks_valid`.
- R3: Samples are taken in every cycle in which the window is already open, including the cycle that carries `rx_end`. The sample in the `rx_wait_done` cycle is not taken. Each held peak equals the largest sample taken on its channel since the window opened.
- R4: Samples presented while the window is closed have no effect on `peak_reg`.
- R5: A `rx_end` pulse while the window is open closes the window and sets `peaks_valid` at that clock edge. The peaks then hold. A `rx_end` while the window is closed is ignored.
- R6: `peak_reg[7:4]` is the in-phase peak and `peak_reg[3:0]` is the quadrature peak (default width 4 bits per channel).
- R7: A `preamble_end` pulse while the window is open sets `chan_sel` to 1 (quadrature) when the quadrature peak held before that cycle is strictly larger than the in-phase peak. Otherwise it sets `chan_sel` to 0 (in-phase), so a tie selects in-phase.
- R8: `chan_sel` changes only on `preamble_end` while the window is open, or on `tx_start`. A `preamble_end` while the window is closed is ignored.
- R9: `tx_start` clears both peaks, `peaks_valid` and `chan_sel`, and closes the window. It takes priority over every other strobe in the same cycle, so a `rx_wait_done` in that cycle does not open the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| amp_i | input | 4 | In-phase amplitude sample |
| amp_q | input | 4 | Quadrature amplitude sample |
| rx_wait_done | input | 1 | Receive wait timer expired (opens window) |
| rx_end | input | 1 | End of reception (closes window) |
| preamble_end | input | 1 | End of preamble (channel decision) |
| tx_start | input | 1 | Start of transmission (clears results) |
| peak_reg | output | 8 | Packed peaks, in-phase high nibble |
| chan_sel | output | 1 | 0 = in-phase chosen, 1 = quadrature chosen |
| peaks_valid | output | 1 | Completed measurement held |

## Verification
A wrong window state shows up in `peak_reg` one cycle later. A window left open after `rx_end` lets a later out-of-window sample raise a held nibble. A window opened one cycle early lets the strobe-cycle sample leak in. A wrong comparison or a lost tie rule shows in `chan_sel` at the edge after `preamble_end`, and that value stays stable until `tx_start`, so the error is visible for the whole hold period. Stale peaks or a stale select bit after `tx_start` are visible at the very next edge.

// File: rtl/rssi_pkg.sv
// Shared types and defaults for the receive peak meter.
// Assumes nothing beyond a two-channel receiver.
package rssi_pkg;
    localparam int AMP_W_DEF = 4;
    localparam int NUM_CH    = 2;

    typedef enum logic {
        SEL_INPHASE = 1'b0,
        SEL_QUAD    = 1'b1
    } chan_t;
endpackage

// File: rtl/rssi_window_ctrl.sv
// Window control: tracks whether the measurement window is open and
// whether a finished result is held. Assumes the strobes are one-cycle
// pulses; tx_start wins over rx_wait_done, which wins over rx_end.
module rssi_window_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_wait_done,
    input  logic rx_end,
    input  logic tx_start,
    output logic win_open,
    output logic clr_peaks,
    output logic res_valid
);
    // Peaks are cleared on any new transmission or new window.
    assign clr_peaks = tx_start | rx_wait_done;

    // Open/close the window and track result validity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_open  <= 1'b0;
            res_valid <= 1'b0;
        end else if (tx_start) begin
            win_open  <= 1'b0;
            res_valid <= 1'b0;
        end else if (rx_wait_done) begin
            win_open  <= 1'b1;
            res_valid <= 1'b0;
        end else if (rx_end && win_open) begin
            win_open  <= 1'b0;
            res_valid <= 1'b1;
        end
    end
endmodule

// File: rtl/rssi_peak_tracker.sv
// Single-channel peak hold: keeps the largest sample seen while enabled.
// Assumes samples are unsigned codes; clear has priority over update.
module rssi_peak_tracker #(
    parameter int W = rssi_pkg::AMP_W_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] sample,
    output logic [W-1:0] peak
);
    // Hold the running maximum; zero it on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            peak <= '0;
        end else if (clr) begin
            peak <= '0;
        end else if (en && (sample > peak)) begin
            peak <= sample;
        end
    end
endmodule

// File: rtl/rssi_chan_picker.sv
// Channel decision: on request, picks the channel with the larger held
// peak; a tie goes to the in-phase channel. Assumes the peaks it sees
// are the registered values before the current cycle's sample.
module rssi_chan_picker #(
    parameter int W = rssi_pkg::AMP_W_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 decide,
    input  logic [W-1:0]         peak_i,
    input  logic [W-1:0]         peak_q,
    output rssi_pkg::chan_t      sel
);
    import rssi_pkg::*;

    // Latch the decision; clear back to in-phase on a new transmission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel <= SEL_INPHASE;
        end else if (clr) begin
            sel <= SEL_INPHASE;
        end else if (decide) begin
            sel <= (peak_q > peak_i) ? SEL_QUAD : SEL_INPHASE;
        end
    end
endmodule

// File: rtl/rssi_peak_capture.sv
// Top: two gated peak meters, a window controller and a channel picker.
// The in-phase peak goes in the high half of the packed result.
// Assumes all strobes are synchronous single-cycle pulses.
module rssi_peak_capture #(
    parameter int AMP_W = rssi_pkg::AMP_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AMP_W-1:0]   amp_i,
    input  logic [AMP_W-1:0]   amp_q,
    input  logic               rx_wait_done,
    input  logic               rx_end,
    input  logic               preamble_end,
    input  logic               tx_start,
    output logic [2*AMP_W-1:0] peak_reg,
    output logic               chan_sel,
    output logic               peaks_valid
);
    import rssi_pkg::*;

    localparam int NCH = NUM_CH;

    logic             win_open;
    logic             clr_peaks;
    logic [AMP_W-1:0] amp_v  [NCH];
    logic [AMP_W-1:0] peak_v [NCH];
    chan_t            sel_w;

    // Channel 0 is in-phase, channel 1 is quadrature.
    assign amp_v[0] = amp_i;
    assign amp_v[1] = amp_q;

    rssi_window_ctrl u_win (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_wait_done (rx_wait_done),
        .rx_end       (rx_end),
        .tx_start     (tx_start),
        .win_open     (win_open),
        .clr_peaks    (clr_peaks),
        .res_valid    (peaks_valid)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_meter
        rssi_peak_tracker #(.W(AMP_W)) u_trk (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr_peaks),
            .en     (win_open),
            .sample (amp_v[c]),
            .peak   (peak_v[c])
        );
    end

    rssi_chan_picker #(.W(AMP_W)) u_pick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tx_start),
        .decide (preamble_end && win_open),
        .peak_i (peak_v[0]),
        .peak_q (peak_v[1]),
        .sel    (sel_w)
    );

    // Pack the result: in-phase high, quadrature low.
    assign peak_reg = {peak_v[0], peak_v[1]};
    assign chan_sel = sel_w;
endmodule

// File: rtl/rssi_peak_checker.sv
// Port-level protocol checks for the receive peak meter.
// Bound to every instance of the top module.
module rssi_peak_checker #(
    parameter int AMP_W = rssi_pkg::AMP_W_DEF
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rx_wait_done,
    input logic               rx_end,
    input logic               preamble_end,
    input logic               tx_start,
    input logic [2*AMP_W-1:0] peak_reg,
    input logic               chan_sel,
    input logic               peaks_valid
);
    assert_tx_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> (peak_reg == '0) && !chan_sel && !peaks_valid);

    assert_open_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_wait_done && !tx_start) |=> (peak_reg == '0) && !peaks_valid);

    assert_valid_from_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(peaks_valid) |-> $past(rx_end));

    assert_iphase_monotonic_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_start && !rx_wait_done) |=>
            (peak_reg[2*AMP_W-1:AMP_W] >= $past(peak_reg[2*AMP_W-1:AMP_W])));

    assert_quad_monotonic_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_start && !rx_wait_done) |=>
            (peak_reg[AMP_W-1:0] >= $past(peak_reg[AMP_W-1:0])));

    assert_hold_when_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (peaks_valid && !tx_start && !rx_wait_done) |=> $stable(peak_reg));

    assert_sel_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_start && !preamble_end) |=> $stable(chan_sel));
endmodule

bind rssi_peak_capture rssi_peak_checker #(.AMP_W(AMP_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_wait_done (rx_wait_done),
    .rx_end       (rx_end),
    .preamble_end (preamble_end),
    .tx_start     (tx_start),
    .peak_reg     (peak_reg),
    .chan_sel     (chan_sel),
    .peaks_valid  (peaks_valid)
);

// File: tb/tb_rssi_peak_capture.sv
module tb_rssi_peak_capture;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] amp_i = '0;
    logic [3:0] amp_q = '0;
    logic       rx_wait_done = 1'b0;
    logic       rx_end = 1'b0;
    logic       preamble_end = 1'b0;
    logic       tx_start = 1'b0;
    logic [7:0] peak_reg;
    logic       chan_sel;
    logic       peaks_valid;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rssi_peak_capture dut (
        .clk(clk), .rst_n(rst_n), .amp_i(amp_i), .amp_q(amp_q),
        .rx_wait_done(rx_wait_done), .rx_end(rx_end),
        .preamble_end(preamble_end), .tx_start(tx_start),
        .peak_reg(peak_reg), .chan_sel(chan_sel), .peaks_valid(peaks_valid)
    );

    // Vector: {i samples s0..s3, q samples s0..s3, preamble index, expected peak, expected sel}
    localparam logic [42:0] VEC [6] = '{
        {16'h3521, 16'h1270, 2'd2, 8'h57, 1'b0},
        {16'h1220, 16'h4109, 2'd1, 8'h29, 1'b1},
        {16'h6000, 16'h6000, 2'd1, 8'h66, 1'b0},
        {16'hFE01, 16'h000F, 2'd3, 8'hFF, 1'b0},
        {16'h0000, 16'h0300, 2'd0, 8'h03, 1'b0},
        {16'h2222, 16'h3333, 2'd3, 8'h23, 1'b1}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        amp_i = '0; amp_q = '0;
        rx_wait_done = 0; rx_end = 0; preamble_end = 0; tx_start = 0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [42:0] cur;
        idle();
        repeat (3) step();
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 peak", peak_reg, 8'h00);
        chk("R1 sel", {7'b0, chan_sel}, 8'h00);
        chk("R1 valid", {7'b0, peaks_valid}, 8'h00);

        // Table walk: R3, R5, R6, R7
        for (int v = 0; v < 6; v++) begin
            cur = VEC[v];
            idle(); tx_start = 1; step();
            idle(); rx_wait_done = 1; step();
            for (int s = 0; s < 4; s++) begin
                idle();
                amp_i = cur[42-4*s -: 4];
                amp_q = cur[26-4*s -: 4];
                preamble_end = (cur[10:9] == s[1:0]);
                rx_end = (s == 3);
                step();
            end
            idle();
            chk($sformatf("R3/R6 peak vec%0d", v), peak_reg, cur[8:1]);
            chk($sformatf("R7 sel vec%0d", v), {7'b0, chan_sel}, {7'b0, cur[0]});
            chk($sformatf("R5 valid vec%0d", v), {7'b0, peaks_valid}, 8'h01);
        end

        // R4: samples after window close ignored; R5 held
        idle(); amp_i = 4'hF; amp_q = 4'hF; step();
        idle(); step();
        chk("R4 peak held", peak_reg, 8'h23);
        // R8: preamble_end with window closed is ignored (sel was 1)
        idle(); preamble_end = 1; amp_i = 4'h9; step();
        idle(); step();
        chk("R8 sel", {7'b0, chan_sel}, 8'h01);
        // R5: rx_end while closed ignored
        idle(); rx_end = 1; step();
        idle(); step();
        chk("R5 valid kept", {7'b0, peaks_valid}, 8'h01);

        // R2: open clears peaks and valid; wait_done-cycle sample not taken (R3)
        idle(); rx_wait_done = 1; amp_i = 4'hE; amp_q = 4'hD; step();
        idle();
        chk("R2 peak cleared", peak_reg, 8'h00);
        chk("R2 valid cleared", {7'b0, peaks_valid}, 8'h00);
        amp_i = 4'h2; amp_q = 4'h1; step();
        idle();
        chk("R3 strobe sample excluded", peak_reg, 8'h21);

        // R9: tx_start clears everything
        idle(); tx_start = 1; step();
        idle();
        chk("R9 peak", peak_reg, 8'h00);
        chk("R9 sel", {7'b0, chan_sel}, 8'h00);
        chk("R9 valid", {7'b0, peaks_valid}, 8'h00);
        // R9: tx_start beats rx_wait_done; window stays closed
        tx_start = 1; rx_wait_done = 1; step();
        idle(); amp_i = 4'h7; amp_q = 4'h8; preamble_end = 1; step();
        idle(); step();
        chk("R9 priority peak", peak_reg, 8'h00);
        chk("R9 priority sel", {7'b0, chan_sel}, 8'h00);

        finish_run();
    end
endmodule